// File: doc/BRIEF.md
# Crosspoint Routing Configuration Store

This block keeps the routing configuration of a crosspoint switch with `NUM_OUT` outputs (32 by default). Each output owns one select word of `SEL_W` bits (6 by default), and that word names the input to connect to the output. The configuration is double-buffered. A control agent fills a staging file one entry at a time, using an output address, an address enable and the input-select value, while the data path keeps using the active bank. The active bank's select words are the block's only outputs.

A transfer strobe commits the staging file. The strobe may arrive asynchronously. It passes through a two-flop synchroniser, and its rising edge then loads every staging entry into the active bank in a single clock edge. Routing therefore changes atomically, whether one output or all of them are rerouted. All writes and transfers are timed by the configuration clock `cfg_clk`. An asynchronous active-low reset clears both banks.

Top module: `xcfg_store`

## Requirements
- R1: While `rst_n` is low, every staging entry and every active entry is zero, so the outputs read zero and a transfer made right after reset also yields zero.
- R2: On a rising edge of `cfg_clk` with `out_addr_en_i` high, staging entry number `out_addr_i` takes the value of `in_sel_i`, and all other staging entries keep their value.
- R3: On a rising edge of `cfg_clk` with `out_addr_en_i` low, no staging entry changes, whatever `out_addr_i` and `in_sel_i` carry.
- R4: Staging writes never change `route_sel_o`; only a transfer does.
- R5: Let `xfer_strobe_i` be sampled high at edge k after being sampled low at edge k-1. At edge k+2 all staging entries are copied into the active bank together, so `route_sel_o[n]` equals staging entry n for every n.
- R6: A strobe held high transfers once only. Staging writes made while it stays high do not reach the outputs until the strobe falls and rises again.
- R7: When a staging write lands on the same edge as a transfer, the transfer copies the entry's value from before that write, and the new value stays in staging for the next transfer.
- R8: A transfer after writes to any subset of entries, from one entry to all of them, changes only the outputs whose staging entries differ from the active ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of both banks |
| out_addr_i | input | ADDR_W (5) | Output whose staging entry is written |
| out_addr_en_i | input | 1 | Write enable for the addressed staging entry |
| in_sel_i | input | SEL_W (6) | Input select value to store |
| xfer_strobe_i | input | 1 | Transfer strobe; its rising edge commits staging to active |
| route_sel_o | output | NUM_OUT x SEL_W (32 x 6) | Active select word for each output |

## Verification
The bound checker watches the internal staging file and the synchronised transfer pulse on every cycle. It checks that enabled writes land in the addressed entry, that disabled cycles leave staging untouched, that the outputs stay still without a pulse, that a pulse copies the previous staging contents (including when a write lands on the same edge), and that a pulse never lasts two cycles. The bench scenarios are needed for what is visible only at the ports. These are the reset values, the two-edge strobe latency counted from the pins, the single commit of a long-held strobe, and the later appearance of a colliding write. Partial and full reroutes are checked against a bench model driven by seeded random traffic.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;
    localparam int NUM_OUT_DEF     = 32;
    localparam int SEL_W_DEF       = 6;
    localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/xcfg_strobe_sync.sv
module xcfg_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic cfg_clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic pulse_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], strobe_i};
        s_d.last  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_o = s_q.chain[STAGES-1] & ~s_q.last;
endmodule

// File: rtl/xcfg_stage_file.sv
module xcfg_stage_file #(
    parameter int NUM_OUT = 32,
    parameter int SEL_W   = 6,
    parameter int ADDR_W  = 5
) (
    input  logic                            cfg_clk,
    input  logic                            rst_n,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               wr_addr_i,
    input  logic [SEL_W-1:0]                wr_sel_i,
    output logic [NUM_OUT-1:0][SEL_W-1:0]   stage_o
);
    typedef struct packed {
        logic [NUM_OUT-1:0][SEL_W-1:0] ent;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (wr_en_i && (wr_addr_i == ADDR_W'(i))) begin
                st_d.ent[i] = wr_sel_i;
            end
        end
    end

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_o = st_q.ent;
endmodule

// File: rtl/xcfg_active_bank.sv
module xcfg_active_bank #(
    parameter int NUM_OUT = 32,
    parameter int SEL_W   = 6
) (
    input  logic                            cfg_clk,
    input  logic                            rst_n,
    input  logic                            load_i,
    input  logic [NUM_OUT-1:0][SEL_W-1:0]   stage_i,
    output logic [NUM_OUT-1:0][SEL_W-1:0]   active_o
);
    typedef struct packed {
        logic [NUM_OUT-1:0][SEL_W-1:0] ent;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (load_i) begin
            bk_d.ent = stage_i;
        end
    end

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign active_o = bk_q.ent;
endmodule

// File: rtl/xcfg_store.sv
module xcfg_store #(
    parameter int  NUM_OUT     = xcfg_pkg::NUM_OUT_DEF,
    parameter int  SEL_W       = xcfg_pkg::SEL_W_DEF,
    parameter int  SYNC_STAGES = xcfg_pkg::SYNC_STAGES_DEF,
    localparam int ADDR_W      = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic                            cfg_clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               out_addr_i,
    input  logic                            out_addr_en_i,
    input  logic [SEL_W-1:0]                in_sel_i,
    input  logic                            xfer_strobe_i,
    output logic [NUM_OUT-1:0][SEL_W-1:0]   route_sel_o
);
    logic                          xfer_pulse;
    logic [NUM_OUT-1:0][SEL_W-1:0] stage_q;

    xcfg_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .cfg_clk  (cfg_clk),
        .rst_n    (rst_n),
        .strobe_i (xfer_strobe_i),
        .pulse_o  (xfer_pulse)
    );

    xcfg_stage_file #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_stage (
        .cfg_clk   (cfg_clk),
        .rst_n     (rst_n),
        .wr_en_i   (out_addr_en_i),
        .wr_addr_i (out_addr_i),
        .wr_sel_i  (in_sel_i),
        .stage_o   (stage_q)
    );

    xcfg_active_bank #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_active (
        .cfg_clk  (cfg_clk),
        .rst_n    (rst_n),
        .load_i   (xfer_pulse),
        .stage_i  (stage_q),
        .active_o (route_sel_o)
    );
endmodule

// File: rtl/xcfg_store_chk.sv
module xcfg_store_chk #(
    parameter int NUM_OUT = 32,
    parameter int SEL_W   = 6,
    parameter int ADDR_W  = 5
) (
    input logic                          cfg_clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [SEL_W-1:0]              wr_sel,
    input logic [NUM_OUT-1:0][SEL_W-1:0] stage,
    input logic                          xfer,
    input logic [NUM_OUT-1:0][SEL_W-1:0] route
);
    assert_write_lands_R2: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        wr_en |=> stage[$past(wr_addr)] == $past(wr_sel));

    assert_no_write_R3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !wr_en |=> $stable(stage));

    assert_route_isolated_R4: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !xfer |=> $stable(route));

    assert_parallel_copy_R5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        xfer |=> route == $past(stage));

    assert_single_pulse_R6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        xfer |=> !xfer);

    assert_old_value_copied_R7: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (xfer && wr_en) |=> route[$past(wr_addr)] == $past(stage[wr_addr]));
endmodule

bind xcfg_store xcfg_store_chk #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
    .cfg_clk (cfg_clk),
    .rst_n   (rst_n),
    .wr_en   (out_addr_en_i),
    .wr_addr (out_addr_i),
    .wr_sel  (in_sel_i),
    .stage   (stage_q),
    .xfer    (xfer_pulse),
    .route   (route_sel_o)
);

// File: tb/xcfg_store_tb.sv
module xcfg_store_tb;
    localparam int N = 32;
    localparam int W = 6;
    localparam int A = 5;

    logic                  cfg_clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [A-1:0]          out_addr_i = '0;
    logic                  out_addr_en_i = 1'b0;
    logic [W-1:0]          in_sel_i = '0;
    logic                  xfer_strobe_i = 1'b0;
    logic [N-1:0][W-1:0]   route_sel_o;

    xcfg_store u_dut (
        .cfg_clk       (cfg_clk),
        .rst_n         (rst_n),
        .out_addr_i    (out_addr_i),
        .out_addr_en_i (out_addr_en_i),
        .in_sel_i      (in_sel_i),
        .xfer_strobe_i (xfer_strobe_i),
        .route_sel_o   (route_sel_o)
    );

    always #5 cfg_clk = ~cfg_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] m_stage [N];
    logic [W-1:0] m_act   [N];
    logic s1, s2, s3;

    function automatic void model_clear();
        for (int i = 0; i < N; i++) begin
            m_stage[i] = '0;
            m_act[i]   = '0;
        end
        s1 = 0; s2 = 0; s3 = 0;
    endfunction

    // One clock: drive at the falling edge, update the model just after the rising edge.
    task automatic cyc(input bit en, input int a, input int s, input bit strb);
        @(negedge cfg_clk);
        out_addr_en_i = en;
        out_addr_i    = A'(a);
        in_sel_i      = W'(s);
        xfer_strobe_i = strb;
        @(posedge cfg_clk);
        #1;
        if (s2 && !s3) begin
            for (int i = 0; i < N; i++) m_act[i] = m_stage[i];
        end
        if (en) m_stage[a] = W'(s);
        s3 = s2; s2 = s1; s1 = strb;
    endtask

    task automatic check_all(input string tag);
        bit bad = 0;
        checks++;
        for (int i = 0; i < N; i++) begin
            if (route_sel_o[i] !== m_act[i]) begin
                $display("FAIL %s: output %0d got %0d expected %0d", tag, i, route_sel_o[i], m_act[i]);
                bad = 1;
            end
        end
        if (bad) fails++;
    endtask

    task automatic commit();
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge cfg_clk);
        rst_n = 0;
        out_addr_en_i = 0;
        xfer_strobe_i = 0;
        model_clear();
        #1;
        @(negedge cfg_clk);
        @(negedge cfg_clk);
        rst_n = 1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        int old_e;
        void'($urandom(32'h5eed_0042));
        model_clear();
        repeat (3) @(posedge cfg_clk);
        #1;
        check_all("R1 outputs zero in reset");
        @(negedge cfg_clk);
        rst_n = 1;
        commit();
        check_all("R1 staging cleared by reset");

        // Several writes leave the outputs alone, then one commit applies them.
        for (int i = 0; i < 8; i++) cyc(1, i * 3, 10 + i, 0);
        check_all("R4 writes do not move outputs");
        commit();
        check_all("R2 R5 written entries committed");

        // Enable low: address and value toggle but nothing is stored.
        for (int i = 0; i < 20; i++) cyc(0, $urandom_range(0, N - 1), $urandom_range(0, 63), 0);
        commit();
        check_all("R3 disabled writes ignored");

        // Single-entry reroute, then a full reroute.
        cyc(1, 17, 42, 0);
        commit();
        check_all("R8 one output rerouted");
        for (int i = 0; i < N; i++) cyc(1, i, 63 - i, 0);
        check_all("R4 full rewrite invisible before commit");
        commit();
        check_all("R8 all outputs rerouted");

        // Latency: active changes at the second edge after the first high sample.
        cyc(1, 5, 7, 0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        check_all("R5 no change one edge after sampling");
        cyc(0, 0, 0, 1);
        check_all("R5 committed two edges after sampling");

        // Strobe stays high: later writes are not committed.
        for (int i = 0; i < 6; i++) cyc(1, i, 50 + i, 1);
        check_all("R6 held strobe commits once");
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        commit();
        check_all("R6 new rise commits pending writes");

        // Write lands on the commit edge.
        old_e = int'(m_stage[9]);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(1, 9, (old_e + 21) % 64, 1);
        check_all("R7 commit takes pre-write value");
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        commit();
        check_all("R7 colliding write committed later");

        // Random traffic with occasional commits.
        for (int k = 0; k < 40; k++) begin
            for (int j = 0; j < 6; j++)
                cyc($urandom_range(0, 1), $urandom_range(0, N - 1), $urandom_range(0, 63), 0);
            check_all("R4 random writes keep outputs");
            if (k % 3 == 0) begin
                commit();
                check_all("R8 random subset commit");
            end
        end

        // Reset in the middle of operation.
        do_reset();
        check_all("R1 outputs cleared by mid-run reset");
        commit();
        check_all("R1 staging cleared by mid-run reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule